// File: doc/BRIEF.md
# Video Memory Write Mailbox with Auto-Incrementing Address

This block lets a slow processor with an 8-bit bus deposit bytes into video memory without knowing when that memory is free. The processor raises one of three strobes, each with a byte on the shared bus. Two strobes preset the low or the high byte of a memory address counter. The third places a data byte in a single-entry holding register and marks it pending. The strobes are asynchronous to the video clock and are brought across with a synchroniser and a rising-edge detector.

The video controller drives `slot_ok` high during cycles in which memory may be written, for example during blanking. When a slot is offered and a byte is pending, the block asserts the memory write enable for that cycle. It presents the held byte and the current counter value. On that clock edge the pending mark is cleared and the counter advances by one. The processor can therefore stream bytes to consecutive addresses after a single address preset. It watches `busy` to avoid overwriting a byte that has not yet been committed.

Top module: `vwb_write_buffer`

## Requirements
- R1: While reset is asserted, and after it is released until a strobe is seen, `busy` and `mem_we` are 0 and `mem_addr` is 0x0000.
- R2: After `cpu_data_stb` rises between clock edges, `busy` is still 0 after the first and second rising clock edges and is 1 after the third. From then on, `mem_wdata` shows the byte that was on `cpu_data` at that third edge.
- R3: `mem_we` is 1 only in a cycle where `slot_ok` is 1 and a byte is pending. A slot offered with nothing pending produces no write.
- R4: In a write cycle, `mem_addr` and `mem_wdata` carry the counter value and the held byte. On that edge `busy` returns to 0 and the counter advances by one.
- R5: While `slot_ok` stays 0, a pending byte is kept indefinitely: `busy` stays 1, no write occurs, and the address does not change.
- R6: A second data strobe that arrives while a byte is pending replaces the held byte. The next slot writes only the newer byte, once.
- R7: `cpu_alo_stb` loads the bus into address bits 7:0 and `cpu_ahi_stb` loads it into bits 15:8, each with the same three-edge latency as R2. The other byte is unchanged.
- R8: The address counter wraps from 0xFFFF to 0x0000 after a write.
- R9: If an address-byte load and a write land on the same edge, the loaded byte takes the bus value and the other byte takes its value from the incremented address. For example, 0x00FF with a high load of 0x55 gives 0x5500.
- R10: A strobe held high for many cycles counts as one event. It yields a single pending byte and a single write, however many slots follow.
- R11: If a data strobe and a write land on the same edge, the write carries the previously held byte. The new byte stays pending and is written at the next address in a later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_data | input | 8 | Processor byte bus, held stable while a strobe is high |
| cpu_data_stb | input | 1 | Asynchronous strobe: take the bus as a data byte |
| cpu_alo_stb | input | 1 | Asynchronous strobe: take the bus as address bits 7:0 |
| cpu_ahi_stb | input | 1 | Asynchronous strobe: take the bus as address bits 15:8 |
| slot_ok | input | 1 | Video side permits a memory write this cycle |
| busy | output | 1 | A byte is pending and not yet committed |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address: the address counter |
| mem_wdata | output | 8 | Memory write data: the held byte |

## Verification
The hardest situations to reach are the collisions of R9 and R11. In each, a processor event, which arrives three clock edges after its strobe, must land on exactly the edge on which a granted slot commits. The stimulus raises the strobe just after a falling clock edge and opens the slot two cycles later, so both actions meet on the third rising edge. The bench then checks the written byte, the resulting address and the pending state. A scoreboard queue records every write the requirements predict, which lets it catch both missing writes and extra ones, such as a second write from a strobe held high.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  // strobe lanes of the processor side, in the order they are synchronised
  localparam int unsigned NUM_STB  = 3;
  localparam int unsigned STB_DATA = 0;
  localparam int unsigned STB_ALO  = 1;
  localparam int unsigned STB_AHI  = 2;
endpackage

// File: rtl/vwb_rst_sync.sv
module vwb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] q_d;

  always_comb q_d = {q_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) q_q <= '0;
    else              q_q <= q_d;
  end

  assign rst_sync_n = q_q[STAGES-1];
endmodule

// File: rtl/vwb_sync_edge.sv
module vwb_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic evt
);
  // STAGES synchroniser flops plus one flop of history for edge detection
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign evt = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/vwb_addr_ctr.sv
module vwb_addr_ctr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_ld,
  input  logic              hi_ld,
  input  logic              inc,
  input  logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = lo_ld | hi_ld | inc;
    addr_d  = inc ? addr_q + ADDR_W'(1) : addr_q;
    // a byte load overrides the matching byte of the stepped value
    if (lo_ld) addr_d[DATA_W-1:0]      = bus;
    if (hi_ld) addr_d[ADDR_W-1:DATA_W] = bus[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/vwb_mailbox.sv
module vwb_mailbox #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] bus,
  input  logic              slot_ok,
  output logic              pending,
  output logic              commit,
  output logic [DATA_W-1:0] hold
);
  logic              pend_q;
  logic              pend_d;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    commit = slot_ok & pend_q;
    // a fresh load keeps the flag set even when the old byte leaves
    pend_d = load | (pend_q & ~commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= bus;
  end

  assign pending = pend_q;
  assign hold    = hold_q;
endmodule

// File: rtl/vwb_write_buffer.sv
module vwb_write_buffer
  import vwb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_data_stb,
  input  logic              cpu_alo_stb,
  input  logic              cpu_ahi_stb,
  input  logic              slot_ok,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic               rst_sync_n;
  logic [NUM_STB-1:0] stb_raw;
  logic [NUM_STB-1:0] stb_evt;
  logic               data_evt;
  logic               alo_evt;
  logic               ahi_evt;
  logic               commit;

  vwb_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  always_comb begin
    stb_raw           = '0;
    stb_raw[STB_DATA] = cpu_data_stb;
    stb_raw[STB_ALO]  = cpu_alo_stb;
    stb_raw[STB_AHI]  = cpu_ahi_stb;
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    vwb_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .async_in (stb_raw[g]),
      .evt      (stb_evt[g])
    );
  end

  assign data_evt = stb_evt[STB_DATA];
  assign alo_evt  = stb_evt[STB_ALO];
  assign ahi_evt  = stb_evt[STB_AHI];

  vwb_mailbox #(.DATA_W(DATA_W)) i_mailbox (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (data_evt),
    .bus     (cpu_data),
    .slot_ok (slot_ok),
    .pending (busy),
    .commit  (commit),
    .hold    (mem_wdata)
  );

  vwb_addr_ctr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_addr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lo_ld (alo_evt),
    .hi_ld (ahi_evt),
    .inc   (commit),
    .bus   (cpu_data),
    .addr  (mem_addr)
  );

  assign mem_we = commit;
endmodule

// File: rtl/vwb_write_buffer_chk.sv
module vwb_write_buffer_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              slot_ok,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              data_evt,
  input logic              lo_evt,
  input logic              hi_evt
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!busy && !mem_we && mem_addr == '0));

  a_r2_busy_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(data_evt));

  a_r3_write_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (slot_ok && busy));

  a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !data_evt) |=> !busy);

  a_r4_commit_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !lo_evt && !hi_evt) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !data_evt |=> $stable(mem_wdata));

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !lo_evt && !hi_evt) |=> $stable(mem_addr));

  a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |=> busy);
endmodule

bind vwb_write_buffer vwb_write_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .slot_ok   (slot_ok),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .data_evt  (data_evt),
  .lo_evt    (alo_evt),
  .hi_evt    (ahi_evt)
);

// File: tb/test_vwb_write_buffer.sv
module test_vwb_write_buffer;
  logic        clk;
  logic        rst_n;
  logic [7:0]  cpu_data;
  logic        cpu_data_stb;
  logic        cpu_alo_stb;
  logic        cpu_ahi_stb;
  logic        slot_ok;
  logic        busy;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  // bench-side model of the requirements
  logic [15:0] m_addr    = 16'h0000;
  logic [7:0]  m_data    = 8'h00;
  bit          m_pending = 1'b0;
  logic [23:0] exp_q[$];

  vwb_write_buffer i_vwb_write_buffer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_data     (cpu_data),
    .cpu_data_stb (cpu_data_stb),
    .cpu_alo_stb  (cpu_alo_stb),
    .cpu_ahi_stb  (cpu_ahi_stb),
    .slot_ok      (slot_ok),
    .busy         (busy),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write must match the oldest expected item
  always @(negedge clk) begin
    #2;
    if (rst_n && mem_we) begin
      chk(slot_ok == 1'b1, "R3 write outside slot", {31'd0, slot_ok}, 32'd1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected write", {8'd0, mem_addr, mem_wdata}, 32'd0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R4 write address/data", {8'd0, mem_addr, mem_wdata}, {8'd0, e});
      end
    end
  end

  // strobe one lane with a full-length pulse; 0 data, 1 low addr, 2 high addr
  task automatic pulse(input int lane, input logic [7:0] val);
    @(negedge clk);
    cpu_data = val;
    case (lane)
      0: cpu_data_stb = 1'b1;
      1: cpu_alo_stb  = 1'b1;
      default: cpu_ahi_stb = 1'b1;
    endcase
    repeat (4) @(negedge clk);
    cpu_data_stb = 1'b0;
    cpu_alo_stb  = 1'b0;
    cpu_ahi_stb  = 1'b0;
    repeat (3) @(negedge clk);
    case (lane)
      0: begin m_data = val; m_pending = 1'b1; end
      1: m_addr[7:0]  = val;
      default: m_addr[15:8] = val;
    endcase
  endtask

  task automatic grant();
    @(negedge clk);
    if (m_pending) begin
      exp_q.push_back({m_addr, m_data});
      m_addr    = m_addr + 16'd1;
      m_pending = 1'b0;
    end
    slot_ok = 1'b1;
    @(negedge clk);
    slot_ok = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_data = 8'h00; cpu_data_stb = 1'b0;
    cpu_alo_stb = 1'b0; cpu_ahi_stb = 1'b0; slot_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && mem_addr == 16'h0, "R1 reset state", {15'd0, busy, mem_addr}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && mem_addr == 16'h0, "R1 after release", {15'd0, busy, mem_addr}, 32'd0);

    // R3: slot with nothing pending gives no write (monitor flags any)
    grant();
    chk(!busy, "R3 idle slot", {31'd0, busy}, 32'd0);

    // R2: three-edge latency of a data strobe
    @(negedge clk);
    cpu_data = 8'hA5; cpu_data_stb = 1'b1;
    @(negedge clk);
    chk(!busy, "R2 after edge 1", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(!busy, "R2 after edge 2", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(busy && mem_wdata == 8'hA5, "R2 after edge 3", {23'd0, busy, mem_wdata}, {23'd0, 1'b1, 8'hA5});
    cpu_data_stb = 1'b0;
    repeat (3) @(negedge clk);
    m_data = 8'hA5; m_pending = 1'b1;

    // R5: no slot, byte kept
    repeat (20) @(negedge clk);
    chk(busy && mem_addr == 16'h0, "R5 held without slot", {15'd0, busy, mem_addr}, {15'd0, 1'b1, 16'h0});
    grant();
    chk(!busy && mem_addr == 16'h0001, "R4 clear and step", {15'd0, busy, mem_addr}, 32'h1);

    // R7: address byte loads
    pulse(1, 8'h34);
    pulse(2, 8'h12);
    chk(mem_addr == 16'h1234, "R7 both bytes", {16'd0, mem_addr}, 32'h1234);
    pulse(1, 8'h80);
    chk(mem_addr == 16'h1280, "R7 low only", {16'd0, mem_addr}, 32'h1280);

    // streaming: consecutive writes
    for (int i = 0; i < 4; i++) begin
      pulse(0, 8'h10 + 8'(i));
      grant();
    end
    chk(mem_addr == 16'h1284, "R4 streaming address", {16'd0, mem_addr}, 32'h1284);

    // R6: overwrite while pending
    pulse(0, 8'h66);
    pulse(0, 8'h77);
    chk(busy && mem_wdata == 8'h77, "R6 overwritten byte", {23'd0, busy, mem_wdata}, {23'd0, 1'b1, 8'h77});
    grant();
    grant();
    chk(mem_addr == 16'h1285 && !busy, "R6 single write", {15'd0, busy, mem_addr}, 32'h1285);

    // R8: wrap
    pulse(1, 8'hFF);
    pulse(2, 8'hFF);
    pulse(0, 8'h5A);
    grant();
    chk(mem_addr == 16'h0000, "R8 wrap", {16'd0, mem_addr}, 32'h0);

    // R9: high-byte load meets a write
    pulse(1, 8'hFF);
    pulse(2, 8'h00);
    pulse(0, 8'hC3);
    @(negedge clk);
    cpu_data = 8'h55; cpu_ahi_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp_q.push_back({16'h00FF, 8'hC3});
    m_pending = 1'b0;
    slot_ok = 1'b1;
    @(negedge clk);
    slot_ok = 1'b0;
    chk(mem_addr == 16'h5500 && !busy, "R9 load beats step", {15'd0, busy, mem_addr}, 32'h5500);
    cpu_ahi_stb = 1'b0;
    repeat (3) @(negedge clk);
    m_addr = 16'h5500;

    // R11: data strobe meets a write
    pulse(0, 8'h21);
    @(negedge clk);
    cpu_data = 8'h42; cpu_data_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp_q.push_back({16'h5500, 8'h21});
    slot_ok = 1'b1;
    @(negedge clk);
    slot_ok = 1'b0;
    chk(busy && mem_wdata == 8'h42, "R11 new byte pending", {23'd0, busy, mem_wdata}, {23'd0, 1'b1, 8'h42});
    cpu_data_stb = 1'b0;
    repeat (3) @(negedge clk);
    m_addr = 16'h5501; m_data = 8'h42; m_pending = 1'b1;
    grant();
    chk(mem_addr == 16'h5502, "R11 next address", {16'd0, mem_addr}, 32'h5502);

    // R10: strobe held high through several slots
    @(negedge clk);
    cpu_data = 8'h99; cpu_data_stb = 1'b1;
    repeat (3) @(negedge clk);
    m_data = 8'h99; m_pending = 1'b1;
    for (int k = 0; k < 3; k++) grant();
    repeat (6) @(negedge clk);
    chk(!busy && mem_addr == 16'h5503, "R10 one event", {15'd0, busy, mem_addr}, 32'h5503);
    cpu_data_stb = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy, "R10 release no event", {31'd0, busy}, 32'd0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule